// File: doc/BRIEF.md
# Replicated Channel Control Register Bank

This block holds the control registers of eight identical channel instances behind one parallel processor bus. The top nibble of the 12-bit bus address picks an instance and the low byte picks a register inside it. Reads are combinational from the address. Writes take effect on the clock edge at which the write strobe is high. One reserved instance code sends a single write to the same register of every instance at once. This lets software set up all channels with one access.

Each register returns to a fixed reset value in three cases: when the hardware reset pin is low, when its own instance issues a software reset, and when a global reset is requested. The global reset is requested from a single global register at the top of the address map. Bits that a register does not implement read as zero and ignore writes. The channel datapaths that consume these registers are not part of the block.

Top module: `regbank_top`

## Requirements
- R1: Address bits [11:8] form the instance code. Codes 0 to 7 select instance 0 to 7. A write changes only the addressed register of the addressed instance. A read returns that register.
- R2: Address bits [7:0] form the register offset. Offsets 0 to 3 are registers. A write at offset 4 or above changes nothing, and a read there returns 0.
- R3: Code 8 is the broadcast code. A write with code 8 and a valid offset stores the data into that offset of all eight instances on the same edge. A read with code 8 returns the register of instance 0.
- R4: While the reset pin is low, every instance register r holds its reset value and the global register holds 0. The reset value of register r is 0xA5C3 rotated left by 4*r bits. The unused bit of that register is then cleared, and for register 3 bit 0 is also cleared. This gives 0xA5C3, 0x5C3A, 0xC3A5 and 0x3A58.
- R5: Register r has one unused bit, at position (5*r+3) mod 16: bits 3, 8, 13 and 2. The unused bit always reads 0, and writing 1 to it has no effect.
- R6: Codes 9 to 14 are unmapped. Writes there change nothing, and reads return 0. Code 15 holds the global register at offset 0 only. Other offsets under code 15 behave as unmapped.
- R7: Bit 0 of register 3 is the instance software-reset bit. A write that moves it from 1 to 0 puts every register of that instance back to its reset value on that edge. Other instances are not affected. With a broadcast write of 0 to bit 0, only the instances whose bit was 1 are reset.
- R8: Writing 1 to bit 0 of the global register sets that bit. On the next edge the bit clears by itself and all instances take their reset values. Bits [15:1] of the global register keep the value last written to them.
- R9: A reset from R7 or R8 takes priority over an instance write on the same edge, and that write is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and register clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| bus_addr | input | 12 | Instance code [11:8] and register offset [7:0] |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data for bus_addr |

## Verification
The hardest case to reach is a reset landing on the same edge as a competing write. The global reset fires one cycle after it is requested, so the bench writes the request bit and then, in the very next cycle, issues an instance write. That write must be lost. In the same way, a broadcast write of 0 to the software-reset bit is sent while only some instances have that bit set. The bench then reads back every instance to confirm that only those instances were reset. A long stretch of mixed random accesses, which can also hit the global reset, is compared every cycle against a behavioural model.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

  // all-ones mask of dw bits held in a 32-bit word
  function automatic logic [31:0] full_mask(int dw);
    return (dw >= 32) ? 32'hFFFF_FFFF : ((32'h1 << dw) - 32'h1);
  endfunction

  // one unimplemented bit per register, spread across the word
  function automatic logic [31:0] used_mask(int r, int dw);
    return full_mask(dw) & ~(32'h1 << ((5 * r + 3) % dw));
  endfunction

  // reset value: seed rotated left by 4*r, unused bit cleared,
  // software-reset bit of the control register cleared
  function automatic logic [31:0] rst_value(int r, int dw, logic [31:0] seed, int ctrl);
    int          rot;
    logic [31:0] s;
    logic [31:0] v;
    s   = seed & full_mask(dw);
    rot = (4 * r) % dw;
    v   = (rot == 0) ? s : (((s << rot) | (s >> (dw - rot))) & full_mask(dw));
    v   = v & used_mask(r, dw);
    if (r == ctrl) v[0] = 1'b0;
    return v;
  endfunction

endpackage

// File: rtl/regbank_decode.sv
module regbank_decode #(
  parameter int NUM_INST = 8,
  parameter int NUM_REGS = 4,
  parameter int ADDR_W   = 12,
  parameter int CODE_W   = 4,
  localparam int OFF_W   = ADDR_W - CODE_W,
  localparam int RIDX_W  = $clog2(NUM_REGS),
  localparam int IIDX_W  = $clog2(NUM_INST)
) (
  input  logic [ADDR_W-1:0]   addr,
  input  logic                we,
  output logic [NUM_INST-1:0] inst_we,
  output logic [RIDX_W-1:0]   ridx,
  output logic [IIDX_W-1:0]   inst_code,
  output logic                off_ok,
  output logic                bcast_hit,
  output logic                inst_rd,
  output logic                glob_sel,
  output logic                glob_we
);
  localparam logic [CODE_W-1:0] BCAST_CODE = {1'b1, {(CODE_W-1){1'b0}}};
  localparam logic [CODE_W-1:0] GLOB_CODE  = '1;
  localparam logic [CODE_W-1:0] NINST_CODE = CODE_W'(NUM_INST);
  localparam logic [OFF_W-1:0]  NREG_OFF   = OFF_W'(NUM_REGS);

  logic [CODE_W-1:0] code;
  logic [OFF_W-1:0]  off;

  assign code      = addr[ADDR_W-1 -: CODE_W];
  assign off       = addr[OFF_W-1:0];
  assign off_ok    = off < NREG_OFF;
  assign ridx      = off[RIDX_W-1:0];
  assign inst_code = code[IIDX_W-1:0];
  assign bcast_hit = code == BCAST_CODE;
  assign inst_rd   = (code < NINST_CODE) && off_ok;
  assign glob_sel  = (code == GLOB_CODE) && (off == '0);
  assign glob_we   = we && glob_sel;

  for (genvar i = 0; i < NUM_INST; i++) begin : g_we
    assign inst_we[i] = we && off_ok && (bcast_hit || (code == CODE_W'(i)));
  end
endmodule

// File: rtl/regbank_inst.sv
module regbank_inst
  import regbank_pkg::*;
#(
  parameter int          NUM_REGS = 4,
  parameter int          DATA_W   = 16,
  parameter logic [31:0] SEED     = 32'h0000_A5C3,
  localparam int         RIDX_W   = $clog2(NUM_REGS),
  localparam int         CTRL_IDX = NUM_REGS - 1
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             we,
  input  logic [RIDX_W-1:0]                ridx,
  input  logic [DATA_W-1:0]                wdata,
  input  logic                             glob_fire,
  output logic                             soft_fire,
  output logic [NUM_REGS-1:0][DATA_W-1:0]  regs_q
);
  localparam logic [RIDX_W-1:0] CTRL_OFF = RIDX_W'(CTRL_IDX);

  logic wipe;

  // software reset: control bit 0 written from 1 to 0
  assign soft_fire = we && (ridx == CTRL_OFF) && !wdata[0] && regs_q[CTRL_IDX][0];
  assign wipe      = soft_fire || glob_fire;

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    localparam logic [DATA_W-1:0] RV   = DATA_W'(rst_value(r, DATA_W, SEED, CTRL_IDX));
    localparam logic [DATA_W-1:0] MASK = DATA_W'(used_mask(r, DATA_W));
    logic hit;
    assign hit = we && (ridx == RIDX_W'(r));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    regs_q[r] <= RV;
      else if (wipe) regs_q[r] <= RV;
      else if (hit)  regs_q[r] <= wdata & MASK;
    end
  end
endmodule

// File: rtl/regbank_glob.sv
module regbank_glob #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] glob_q,
  output logic              glob_fire
);
  // bit 0 is a one-shot request; it fires while set and clears on the same edge
  assign glob_fire = glob_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glob_q <= '0;
    end else if (we) begin
      glob_q <= {wdata[DATA_W-1:1], wdata[0] & ~glob_q[0]};
    end else begin
      glob_q[0] <= 1'b0;
    end
  end
endmodule

// File: rtl/regbank_rdmux.sv
module regbank_rdmux #(
  parameter int NUM_INST = 8,
  parameter int NUM_REGS = 4,
  parameter int DATA_W   = 16,
  localparam int RIDX_W  = $clog2(NUM_REGS),
  localparam int IIDX_W  = $clog2(NUM_INST)
) (
  input  logic [NUM_INST-1:0][NUM_REGS-1:0][DATA_W-1:0] all_regs,
  input  logic [DATA_W-1:0]                             glob_q,
  input  logic [RIDX_W-1:0]                             ridx,
  input  logic [IIDX_W-1:0]                             inst_code,
  input  logic                                          off_ok,
  input  logic                                          bcast_hit,
  input  logic                                          inst_rd,
  input  logic                                          glob_sel,
  output logic [DATA_W-1:0]                             rdata
);
  always_comb begin
    rdata = '0;
    if (glob_sel)                rdata = glob_q;
    else if (bcast_hit && off_ok) rdata = all_regs[0][ridx];
    else if (inst_rd)            rdata = all_regs[inst_code][ridx];
  end
endmodule

// File: rtl/regbank_top.sv
module regbank_top #(
  parameter int          NUM_INST = 8,
  parameter int          NUM_REGS = 4,
  parameter int          DATA_W   = 16,
  parameter int          ADDR_W   = 12,
  parameter int          CODE_W   = 4,
  parameter logic [31:0] SEED     = 32'h0000_A5C3,
  localparam int         RIDX_W   = $clog2(NUM_REGS),
  localparam int         IIDX_W   = $clog2(NUM_INST)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata
);
  logic [NUM_INST-1:0]                        inst_we_w;
  logic [NUM_INST-1:0]                        soft_fire_w;
  logic [NUM_INST-1:0][NUM_REGS-1:0][DATA_W-1:0] regs_w;
  logic [RIDX_W-1:0]                          ridx_w;
  logic [IIDX_W-1:0]                          inst_code_w;
  logic                                       off_ok_w;
  logic                                       bcast_hit_w;
  logic                                       inst_rd_w;
  logic                                       glob_sel_w;
  logic                                       glob_we_w;
  logic                                       glob_fire_w;
  logic [DATA_W-1:0]                          glob_q_w;

  regbank_decode #(
    .NUM_INST(NUM_INST), .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W), .CODE_W(CODE_W)
  ) decode_i (
    .addr(bus_addr), .we(bus_we), .inst_we(inst_we_w), .ridx(ridx_w),
    .inst_code(inst_code_w), .off_ok(off_ok_w), .bcast_hit(bcast_hit_w),
    .inst_rd(inst_rd_w), .glob_sel(glob_sel_w), .glob_we(glob_we_w)
  );

  regbank_glob #(.DATA_W(DATA_W)) glob_i (
    .clk(clk), .rst_n(rst_n), .we(glob_we_w), .wdata(bus_wdata),
    .glob_q(glob_q_w), .glob_fire(glob_fire_w)
  );

  for (genvar i = 0; i < NUM_INST; i++) begin : g_inst
    regbank_inst #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .SEED(SEED)) inst_i (
      .clk(clk), .rst_n(rst_n), .we(inst_we_w[i]), .ridx(ridx_w),
      .wdata(bus_wdata), .glob_fire(glob_fire_w),
      .soft_fire(soft_fire_w[i]), .regs_q(regs_w[i])
    );
  end

  regbank_rdmux #(.NUM_INST(NUM_INST), .NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) rdmux_i (
    .all_regs(regs_w), .glob_q(glob_q_w), .ridx(ridx_w), .inst_code(inst_code_w),
    .off_ok(off_ok_w), .bcast_hit(bcast_hit_w), .inst_rd(inst_rd_w),
    .glob_sel(glob_sel_w), .rdata(bus_rdata)
  );
endmodule

// File: rtl/regbank_chk.sv
module regbank_chk
  import regbank_pkg::*;
#(
  parameter int          NUM_INST = 8,
  parameter int          NUM_REGS = 4,
  parameter int          DATA_W   = 16,
  parameter int          ADDR_W   = 12,
  parameter int          CODE_W   = 4,
  parameter logic [31:0] SEED     = 32'h0000_A5C3,
  localparam int         OFF_W    = ADDR_W - CODE_W
) (
  input logic                clk,
  input logic                rst_n,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic                bus_we,
  input logic [DATA_W-1:0]   bus_rdata,
  input logic [NUM_INST-1:0] inst_we,
  input logic [NUM_INST-1:0] soft_fire,
  input logic                glob_fire
);
  logic [CODE_W-1:0]   code;
  logic [OFF_W-1:0]    off;
  logic                off_ok;
  logic                rd_inst;
  logic                is_bcast;
  logic [NUM_INST-1:0] soft_prev;

  assign code     = bus_addr[ADDR_W-1 -: CODE_W];
  assign off      = bus_addr[OFF_W-1:0];
  assign off_ok   = off < OFF_W'(NUM_REGS);
  assign is_bcast = code == CODE_W'(NUM_INST);
  assign rd_inst  = (code < CODE_W'(NUM_INST)) && off_ok;

  function automatic logic [DATA_W-1:0] exp_rv(logic [OFF_W-1:0] o);
    return DATA_W'(rst_value(int'(o), DATA_W, SEED, NUM_REGS - 1));
  endfunction

  function automatic logic [DATA_W-1:0] exp_mask(logic [OFF_W-1:0] o);
    return DATA_W'(used_mask(int'(o), DATA_W));
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) soft_prev <= '0;
    else        soft_prev <= soft_fire;
  end

  AST_SINGLE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    !is_bcast |-> $onehot0(inst_we)); // R1
  AST_OFFSET_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !off_ok |-> (inst_we == '0) && (bus_rdata == '0)); // R2
  AST_BCAST_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && is_bcast && off_ok) |-> (&inst_we)); // R3
  AST_HW_RESET_VALUE: assert property (@(posedge clk)
    $rose(rst_n) |-> (!rd_inst || (bus_rdata == exp_rv(off)))); // R4
  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_inst |-> ((bus_rdata & ~exp_mask(off)) == '0)); // R5
  AST_UNMAPPED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (code > CODE_W'(NUM_INST)) |-> (inst_we == '0)); // R6
  AST_SOFT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_inst && (soft_prev != '0)) |-> (!soft_prev[code[$clog2(NUM_INST)-1:0]] || (bus_rdata == exp_rv(off)))); // R7
  AST_GLOB_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    glob_fire |=> !glob_fire); // R8
  AST_GLOB_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    glob_fire |=> (!rd_inst || (bus_rdata == exp_rv(off)))); // R9
endmodule

bind regbank_top regbank_chk #(
  .NUM_INST(NUM_INST), .NUM_REGS(NUM_REGS), .DATA_W(DATA_W),
  .ADDR_W(ADDR_W), .CODE_W(CODE_W), .SEED(SEED)
) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_rdata(bus_rdata), .inst_we(inst_we_w), .soft_fire(soft_fire_w),
  .glob_fire(glob_fire_w)
);

// File: tb/regbank_top_tb_top.sv
module regbank_top_tb_top;
  localparam int NI = 8;
  localparam int NR = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] addr;
  logic        we;
  logic [15:0] wdata;
  logic [15:0] rdata;

  always #10 clk = ~clk;

  regbank_top dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we),
    .bus_wdata(wdata), .bus_rdata(rdata)
  );

  logic [15:0] m [NI][NR];
  logic [15:0] mg;
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  function automatic logic [15:0] b_mask(int r);
    return 16'hFFFF ^ (16'd1 << ((r * 5 + 3) & 15));
  endfunction

  function automatic logic [15:0] b_rst(int r);
    logic [31:0] dbl;
    logic [15:0] v;
    dbl = {16'hA5C3, 16'hA5C3};
    v   = 16'(dbl >> (16 - 4 * r));
    v   = v & b_mask(r);
    if (r == NR - 1) v = v & 16'hFFFE;
    return v;
  endfunction

  function automatic logic [11:0] addr_of(int code, int off);
    return {4'(code), 8'(off)};
  endfunction

  task automatic wipe_inst(int i);
    for (int r = 0; r < NR; r++) m[i][r] = b_rst(r);
  endtask

  task automatic model_init();
    for (int i = 0; i < NI; i++) wipe_inst(i);
    mg = 16'h0000;
  endtask

  function automatic logic [15:0] m_read(logic [11:0] a);
    int c, o;
    c = int'(a[11:8]);
    o = int'(a[7:0]);
    if (c == 15 && o == 0) return mg;
    if (o >= NR)           return 16'h0000;
    if (c < NI)            return m[c][o];
    if (c == 8)            return m[0][o];
    return 16'h0000;
  endfunction

  // behavioural next state, applied after each rising edge
  task automatic m_edge();
    int c, o;
    c = int'(addr[11:8]);
    o = int'(addr[7:0]);
    if (!rst_n) return;
    if (mg[0]) begin
      for (int i = 0; i < NI; i++) wipe_inst(i);
      if (we && c == 15 && o == 0) mg = {wdata[15:1], 1'b0};
      else                         mg[0] = 1'b0;
      return;
    end
    if (!we) return;
    if (c == 15 && o == 0) begin
      mg = wdata;
    end else if (o < NR && (c < NI || c == 8)) begin
      for (int i = 0; i < NI; i++) begin
        if (c == 8 || c == i) begin
          if (o == NR - 1 && m[i][o][0] && !wdata[0]) wipe_inst(i);
          else m[i][o] = wdata & b_mask(o);
        end
      end
    end
  endtask

  task automatic step(bit w, logic [11:0] a, logic [15:0] d, string tag);
    logic [15:0] exp;
    @(negedge clk);
    we = w; addr = a; wdata = d;
    #1;
    exp = m_read(a);
    checks++;
    if (rdata !== exp) begin
      fails++;
      $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, rdata, exp);
    end
    @(posedge clk);
    m_edge();
  endtask

  task automatic rd(logic [11:0] a, string tag);
    step(1'b0, a, 16'h0000, tag);
  endtask

  task automatic wr(logic [11:0] a, logic [15:0] d, string tag);
    step(1'b1, a, d, tag);
  endtask

  task automatic sweep(string tag);
    for (int i = 0; i < NI; i++)
      for (int r = 0; r < NR; r++) rd(addr_of(i, r), tag);
  endtask

  task automatic hw_reset();
    @(negedge clk);
    rst_n = 1'b0; we = 1'b0;
    model_init();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    model_init();
    hw_reset();

    // R4: reset state everywhere, global register zero
    sweep("R4");
    rd(addr_of(15, 0), "R4");

    // R1: distinct data per instance and register
    for (int i = 0; i < NI; i++)
      for (int r = 0; r < NR - 1; r++) wr(addr_of(i, r), 16'(16'h1111 * (i + 1) + r), "R1");
    sweep("R1");

    // R5: all-ones write, unused bit stays clear
    for (int r = 0; r < NR; r++) wr(addr_of(6, r), 16'hFFFE, "R5");
    wr(addr_of(6, 0), 16'hFFFF, "R5");
    for (int r = 0; r < NR; r++) rd(addr_of(6, r), "R5");

    // R3: broadcast write and read at the broadcast code
    wr(addr_of(8, 1), 16'hBEEF, "R3");
    sweep("R3");
    rd(addr_of(8, 0), "R3");
    rd(addr_of(8, 2), "R3");

    // R2: out-of-range offsets
    wr(addr_of(2, 5), 16'h7777, "R2");
    wr(addr_of(1, 8'h84), 16'h7777, "R2");
    rd(addr_of(2, 5), "R2");
    rd(addr_of(1, 8'h84), "R2");
    rd(addr_of(2, 1), "R2");
    rd(addr_of(1, 0), "R2");

    // R6: unmapped codes and stray offsets under the global code
    for (int c = 9; c < 15; c++) wr(addr_of(c, 0), 16'h5555, "R6");
    wr(addr_of(15, 1), 16'h5555, "R6");
    for (int c = 9; c < 15; c++) rd(addr_of(c, 0), "R6");
    rd(addr_of(15, 1), "R6");
    sweep("R6");

    // R7: per-instance software reset
    wr(addr_of(3, 3), 16'h0041, "R7");
    wr(addr_of(5, 3), 16'h0081, "R7");
    wr(addr_of(3, 3), 16'h0040, "R7");
    for (int r = 0; r < NR; r++) rd(addr_of(3, r), "R7");
    for (int r = 0; r < NR; r++) rd(addr_of(5, r), "R7");
    // R7: broadcast clear resets only instance 5
    wr(addr_of(8, 3), 16'h0000, "R7");
    sweep("R7");

    // R8 + R9: global reset, competing write in the firing cycle is lost
    wr(addr_of(2, 0), 16'h4321, "R8");
    wr(addr_of(15, 0), 16'hABC1, "R8");
    wr(addr_of(2, 0), 16'h1234, "R9");
    rd(addr_of(2, 0), "R9");
    rd(addr_of(15, 0), "R8");
    sweep("R8");

    // mixed random traffic checked every cycle
    for (int n = 0; n < 400; n++) begin
      logic [15:0] d;
      int c, o;
      c = $urandom_range(15, 0);
      o = $urandom_range(5, 0);
      d = 16'($urandom);
      step(1'($urandom_range(1, 0)), addr_of(c, o), d, "R1");
    end

    // R4: hardware reset mid-run
    wr(addr_of(4, 2), 16'h0F0F, "R4");
    wr(addr_of(15, 0), 16'hF0F0, "R4");
    hw_reset();
    sweep("R4");
    rd(addr_of(15, 0), "R4");

    done = 1'b1;
    finish_run();
  end
endmodule